// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings a transmit PHY from idle to a powered, locked state and back again. It acts as a small register-bus master. On a power-on request it raises the two clock-enable requests. It checks the state-management clock frequency and derives that clock's divider. It then writes the clock divider, the PLL divider word and the band value, in that order. Next it performs a read-modify-write that starts the PHY's startup machine. Finally it polls two status bits, PLL lock and then common-ready, each under a timeout measured in microsecond ticks.

A power-off request drops both clock enables. It then clears only the enable bit of the startup-machine register through a read-modify-write, and clears the powered flag. If any step of power-up fails, the enables collapse and the powered flag stays low. The failure is reported as a one-cycle pulse, and a sticky code names the step that failed. Divider and band values are computed elsewhere and arrive as plain inputs.

The bus side is a strobe/acknowledge handshake rather than a stream. The block raises one strobe with its address and write data. It holds all of these unchanged until the slave returns `bus_ack`, and it starts no new access until the block has taken in the acknowledge. The slave may insert any number of wait cycles. The control and status pins are plain levels or pulses.

Top module: `phy_pwr_seq`

## Requirements
- R1: A power-on request while idle is rejected when `cfg_valid` is low or `powered` is already high. A rejection gives a one-cycle `err_pulse` with `err_code` = 1 and no bus access, and it leaves `powered` and the clock enables unchanged.
- R2: After acceptance, the clock frequency must be nonzero and no more than 100 000 000 Hz. Otherwise the sequence fails with code 2 before any bus access. The divider is the frequency divided by 1 000 000, rounded to nearest with halves rounding up, and it is sent in bits 7:0 of the first write.
- R3: A successful power-up issues these accesses in order: a write to `A_DIV`, a write of `pll_word` to `A_PLL`, a write to `A_BAND`, a read of `A_SSM`, and then a write to `A_SSM`. The addresses are parameters of the top module.
- R4: The band write carries `band_sel` in bits 4:0 and again in bits 9:5, with zeros above. If `band_ok` is low, the sequence fails with code 3 after the PLL write and before any band write.
- R5: The startup write equals the value just read ANDed with 0x1FE, then ORed with 0x201.
- R6: After the startup write, the block reads `A_PLL` repeatedly until bit 31 is set. It then reads `A_STAT` repeatedly until bit 31 is set. After that, `powered` goes high, `busy` goes low and both clock enables stay high.
- R7: Each poll phase counts `us_tick` from zero, starting at the phase's start. If a poll read returns bit 31 clear once the count has reached `TIMEOUT_US`, the sequence fails, with code 4 for lock or code 5 for ready.
- R8: On any failure, both clock enables and `powered` are low when `err_pulse` is seen. `err_pulse` lasts one cycle. `err_code` holds its value until the next accepted power-on, which clears it to 0.
- R9: A power-off request while idle drops both clock enables on the next cycle. It then reads `A_SSM`, writes back that value with bit 0 cleared, and finally clears `powered`.
- R10: Only one access is outstanding at a time, `bus_wr` and `bus_rd` are never high together, and strobe, address and write data hold steady until `bus_ack`.
- R11: Requests that arrive while `busy` is high are ignored. When both requests arrive together in idle, power-on wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_req | input | 1 | Power-up request pulse |
| pwr_off_req | input | 1 | Power-down request pulse |
| cfg_valid | input | 1 | Divider and band inputs hold a valid configuration |
| sm_freq_hz | input | FREQ_W | State-management clock frequency in Hz |
| pll_word | input | 32 | Precomputed PLL divider register value |
| band_sel | input | BAND_W | Precomputed band index |
| band_ok | input | 1 | Band index is valid |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| clk_en_sm | output | 1 | Enable request for the state-management clock |
| clk_en_ref | output | 1 | Enable request for the PLL reference clock |
| powered | output | 1 | PHY is up |
| busy | output | 1 | A sequence is running |
| err_pulse | output | 1 | One-cycle failure or rejection indication |
| err_code | output | 3 | Sticky failing step: 0 none, 1 rejected, 2 clock, 3 band, 4 lock, 5 ready |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completion |

## Verification
The bench targets the edges of the frequency check: zero, one hertz past the ceiling, and the two sides of a half-megahertz rounding point. A design that truncated instead of rounding, or that used a strict limit, would send the wrong divider or reject a legal clock. It randomizes the startup register's contents, so a read-modify-write that kept the wrong field, or forgot the transmit-mode bit, shows up as a wrong write value. Polls that never succeed check that each phase times out with its own code, and that the enables drop with it. Stray requests during a running sequence, and a simultaneous on/off pair, catch a state machine that restarts or takes the wrong branch.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

  localparam int PPS_DW = 32;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_REJECT = 3'd1,
    ERR_CLOCK  = 3'd2,
    ERR_BAND   = 3'd3,
    ERR_LOCK   = 3'd4,
    ERR_READY  = 3'd5
  } pps_err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLKCHK,
    ST_WDIV,
    ST_WPLL,
    ST_WBAND,
    ST_RSSM,
    ST_WSSM,
    ST_PLOCK,
    ST_PRDY,
    ST_OFFR,
    ST_OFFW
  } pps_state_e;

  // startup register: keep calibration wait field, set enable and tx-mode bits
  localparam logic [PPS_DW-1:0] SSM_KEEP = 32'h0000_01FE;
  localparam logic [PPS_DW-1:0] SSM_SET  = 32'h0000_0201;
  localparam logic [PPS_DW-1:0] SSM_EN   = 32'h0000_0001;

endpackage

// File: rtl/pps_clk_div.sv
module pps_clk_div #(
  parameter int FREQ_W  = 27,
  parameter int DIV_W   = 8,
  parameter int MAX_HZ  = 100_000_000,
  parameter int STEP_HZ = 1_000_000
) (
  input  logic [FREQ_W-1:0] freq_hz,
  output logic              ok,
  output logic [DIV_W-1:0]  div
);
  localparam int HALF   = STEP_HZ / 2;
  localparam int DIV_HI = (MAX_HZ + HALF) / STEP_HZ;

  logic [FREQ_W:0] biased;
  logic [FREQ_W:0] quot;

  always_comb begin
    biased = {1'b0, freq_hz} + (FREQ_W+1)'(HALF);
    quot   = biased / (FREQ_W+1)'(STEP_HZ);
    div    = DIV_W'(quot);
    ok     = (freq_hz != '0) && (freq_hz <= FREQ_W'(MAX_HZ));
  end

  // R2
  always_comb begin
    if (ok) div_range_chk: assert (div <= DIV_W'(DIV_HI));
  end

endmodule

// File: rtl/pps_poll_timer.sv
module pps_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt <= '0;
    else if (clr)                          cnt <= '0;
    else if (tick && (cnt != CW'(LIMIT)))  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);

endmodule

// File: rtl/pps_bus_port.sv
module pps_bus_port #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active && req) begin
        active    <= 1'b1;
        bus_wr    <= req_wr;
        bus_rd    <= !req_wr;
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
      end else if (active && bus_ack) begin
        active <= 1'b0;
        bus_wr <= 1'b0;
        bus_rd <= 1'b0;
        rdata  <= bus_rdata;
        done   <= 1'b1;
      end
    end
  end

  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R10
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ack) |=>
      ((bus_wr || bus_rd) && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr)));

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_wr || bus_rd));

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FREQ_W     = 27,
  parameter int DIV_W      = 8,
  parameter int BAND_W     = 5,
  parameter int TIMEOUT_US = 1000,
  parameter int MAX_SM_HZ  = 100_000_000,
  parameter int STEP_HZ    = 1_000_000,
  parameter logic [ADDR_W-1:0] A_DIV  = 12'h010,
  parameter logic [ADDR_W-1:0] A_PLL  = 12'h020,
  parameter logic [ADDR_W-1:0] A_BAND = 12'h030,
  parameter logic [ADDR_W-1:0] A_SSM  = 12'h040,
  parameter logic [ADDR_W-1:0] A_STAT = 12'h050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic              cfg_valid,
  input  logic [FREQ_W-1:0] sm_freq_hz,
  input  logic [31:0]       pll_word,
  input  logic [BAND_W-1:0] band_sel,
  input  logic              band_ok,
  input  logic              us_tick,
  output logic              clk_en_sm,
  output logic              clk_en_ref,
  output logic              powered,
  output logic              busy,
  output logic              err_pulse,
  output logic [2:0]        err_code,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);
  localparam int SB = PPS_DW - 1;

  pps_state_e        state;
  pps_err_e          code_q;
  logic              issued, clk_en;
  logic              div_ok;
  logic [DIV_W-1:0]  div_val;
  logic              acc_on, acc_req, acc_wr, acc_done;
  logic [ADDR_W-1:0] acc_addr;
  logic [PPS_DW-1:0] acc_wdata, acc_rdata;
  logic              tmr_clr, poll_expired;
  logic              fail_hit;
  pps_err_e          fail_kind;

  pps_clk_div #(
    .FREQ_W (FREQ_W), .DIV_W (DIV_W), .MAX_HZ (MAX_SM_HZ), .STEP_HZ (STEP_HZ)
  ) u_div (
    .freq_hz (sm_freq_hz), .ok (div_ok), .div (div_val)
  );

  pps_poll_timer #(.LIMIT (TIMEOUT_US)) u_tmr (
    .clk (clk), .rst_n (rst_n), .clr (tmr_clr), .tick (us_tick), .expired (poll_expired)
  );

  pps_bus_port #(.AW (ADDR_W), .DW (PPS_DW)) u_port (
    .clk (clk), .rst_n (rst_n),
    .req (acc_req), .req_wr (acc_wr), .req_addr (acc_addr), .req_wdata (acc_wdata),
    .done (acc_done), .rdata (acc_rdata),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_ack (bus_ack)
  );

  // access selected by the current step
  always_comb begin
    acc_on    = 1'b1;
    acc_wr    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    unique case (state)
      ST_WDIV:  begin acc_wr = 1'b1; acc_addr = A_DIV;  acc_wdata = PPS_DW'(div_val); end
      ST_WPLL:  begin acc_wr = 1'b1; acc_addr = A_PLL;  acc_wdata = pll_word; end
      ST_WBAND: begin acc_wr = 1'b1; acc_addr = A_BAND; acc_wdata = PPS_DW'({band_sel, band_sel}); end
      ST_RSSM, ST_OFFR: acc_addr = A_SSM;
      ST_WSSM:  begin acc_wr = 1'b1; acc_addr = A_SSM; acc_wdata = (acc_rdata & SSM_KEEP) | SSM_SET; end
      ST_OFFW:  begin acc_wr = 1'b1; acc_addr = A_SSM; acc_wdata = acc_rdata & ~SSM_EN; end
      ST_PLOCK: acc_addr = A_PLL;
      ST_PRDY:  acc_addr = A_STAT;
      default:  acc_on = 1'b0;
    endcase
    acc_req = acc_on && !issued;
  end

  // failure detection per step
  always_comb begin
    fail_hit  = 1'b0;
    fail_kind = ERR_NONE;
    unique case (state)
      ST_CLKCHK: if (!div_ok) begin fail_hit = 1'b1; fail_kind = ERR_CLOCK; end
      ST_WPLL:   if (acc_done && !band_ok) begin fail_hit = 1'b1; fail_kind = ERR_BAND; end
      ST_PLOCK:  if (acc_done && !acc_rdata[SB] && poll_expired) begin
                   fail_hit = 1'b1; fail_kind = ERR_LOCK;
                 end
      ST_PRDY:   if (acc_done && !acc_rdata[SB] && poll_expired) begin
                   fail_hit = 1'b1; fail_kind = ERR_READY;
                 end
      default: ;
    endcase
  end

  assign tmr_clr = acc_done && ((state == ST_WSSM) || ((state == ST_PLOCK) && acc_rdata[SB]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      issued    <= 1'b0;
      clk_en    <= 1'b0;
      powered   <= 1'b0;
      err_pulse <= 1'b0;
      code_q    <= ERR_NONE;
    end else begin
      err_pulse <= 1'b0;
      if (acc_req)  issued <= 1'b1;
      if (acc_done) issued <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (pwr_on_req) begin
            if (!cfg_valid || powered) begin
              err_pulse <= 1'b1;
              code_q    <= ERR_REJECT;
            end else begin
              clk_en <= 1'b1;
              code_q <= ERR_NONE;
              state  <= ST_CLKCHK;
            end
          end else if (pwr_off_req) begin
            clk_en <= 1'b0;
            state  <= ST_OFFR;
          end
        end
        ST_CLKCHK: state <= ST_WDIV;
        ST_WDIV:   if (acc_done) state <= ST_WPLL;
        ST_WPLL:   if (acc_done) state <= ST_WBAND;
        ST_WBAND:  if (acc_done) state <= ST_RSSM;
        ST_RSSM:   if (acc_done) state <= ST_WSSM;
        ST_WSSM:   if (acc_done) state <= ST_PLOCK;
        ST_PLOCK:  if (acc_done && acc_rdata[SB]) state <= ST_PRDY;
        ST_PRDY:   if (acc_done && acc_rdata[SB]) begin
                     powered <= 1'b1;
                     state   <= ST_IDLE;
                   end
        ST_OFFR:   if (acc_done) state <= ST_OFFW;
        ST_OFFW:   if (acc_done) begin
                     powered <= 1'b0;
                     state   <= ST_IDLE;
                   end
        default:   state <= ST_IDLE;
      endcase
      if (fail_hit) begin
        clk_en    <= 1'b0;
        powered   <= 1'b0;
        err_pulse <= 1'b1;
        code_q    <= fail_kind;
        issued    <= 1'b0;
        state     <= ST_IDLE;
      end
    end
  end

  assign clk_en_sm  = clk_en;
  assign clk_en_ref = clk_en;
  assign busy       = (state != ST_IDLE);
  assign err_code   = code_q;

  // R8
  fail_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && (err_code != ERR_REJECT)) |-> (!clk_en_sm && !clk_en_ref && !powered));

  // R6
  power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> (clk_en_sm && !busy));

  // R1
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_on_req && powered) |=> (powered && err_pulse && (err_code == ERR_REJECT) && !busy));

  // R9
  off_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pwr_on_req && pwr_off_req) |=> (!clk_en_sm && !clk_en_ref && busy));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fail_hit && (state == ST_WDIV)) |=> busy);

endmodule

// File: tb/phy_pwr_seq_tb.sv
module phy_pwr_seq_tb;

  localparam logic [11:0] T_DIV  = 12'h110;
  localparam logic [11:0] T_PLL  = 12'h124;
  localparam logic [11:0] T_BAND = 12'h138;
  localparam logic [11:0] T_SSM  = 12'h14C;
  localparam logic [11:0] T_STAT = 12'h160;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, cfg_valid = 1'b0;
  logic [26:0] sm_freq_hz = '0;
  logic [31:0] pll_word = '0;
  logic [4:0] band_sel = '0;
  logic band_ok = 1'b0, us_tick = 1'b0;
  logic clk_en_sm, clk_en_ref, powered, busy, err_pulse;
  logic [2:0] err_code;
  logic bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  always #10 clk = ~clk;

  phy_pwr_seq #(
    .TIMEOUT_US (TMO),
    .A_DIV (T_DIV), .A_PLL (T_PLL), .A_BAND (T_BAND), .A_SSM (T_SSM), .A_STAT (T_STAT)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .pwr_on_req (pwr_on_req), .pwr_off_req (pwr_off_req),
    .cfg_valid (cfg_valid), .sm_freq_hz (sm_freq_hz), .pll_word (pll_word),
    .band_sel (band_sel), .band_ok (band_ok), .us_tick (us_tick),
    .clk_en_sm (clk_en_sm), .clk_en_ref (clk_en_ref), .powered (powered), .busy (busy),
    .err_pulse (err_pulse), .err_code (err_code),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_ack (bus_ack)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lg_n = 0, err_seen = 0;
  logic        lg_wr   [64];
  logic [11:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [31:0] ssm_reg = 32'h0;
  int lock_after = 0, rdy_after = 0, lock_rd = 0, rdy_rd = 0, wait_left = 0;

  // bus slave model with random wait cycles
  always @(negedge clk) begin
    logic [31:0] r;
    if (!rst_n) bus_ack = 1'b0;
    else if (bus_ack) bus_ack = 1'b0;
    else if (bus_wr || bus_rd) begin
      if (wait_left > 0) wait_left--;
      else begin
        bus_ack = 1'b1;
        lg_wr[lg_n] = bus_wr; lg_addr[lg_n] = bus_addr; lg_data[lg_n] = bus_wdata;
        if (lg_n < 63) lg_n++;
        r = $urandom;
        if (bus_wr) begin
          if (bus_addr == T_SSM) ssm_reg = bus_wdata;
        end else if (bus_addr == T_PLL) begin
          r[31] = (lock_rd >= lock_after); lock_rd++;
        end else if (bus_addr == T_STAT) begin
          r[31] = (rdy_rd >= rdy_after); rdy_rd++;
        end else if (bus_addr == T_SSM) r = ssm_reg;
        bus_rdata = r;
        wait_left = $urandom % 3;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && err_pulse) err_seen++;
  end

  function automatic int exp_div(input int f);
    return (f + 500_000) / 1_000_000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input int idx, input bit wr, input logic [11:0] a,
                         input logic [31:0] d, input bit use_d, input string tag);
    bit ok;
    ok = (lg_wr[idx] == wr) && (lg_addr[idx] == a) && (!use_d || (lg_data[idx] == d));
    chk(ok, tag, {lg_wr[idx], lg_addr[idx], lg_data[idx]}, {wr, a, use_d ? d : lg_data[idx]});
  endtask

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    pwr_on_req = on; pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_up(input int f, input logic [4:0] band, input bit bok,
                        input logic [31:0] pll, input int la, input int ra,
                        input bit both, input bit stray, input int code);
    logic [31:0] ssm0;
    int base;
    sm_freq_hz = f[26:0]; band_sel = band; band_ok = bok; pll_word = pll;
    lock_after = la; rdy_after = ra; lock_rd = 0; rdy_rd = 0;
    ssm0 = ssm_reg; lg_n = 0; err_seen = 0;
    pulse(1'b1, both);
    if (stray) begin
      @(negedge clk); pwr_off_req = 1'b1; pwr_on_req = 1'b1;
      @(negedge clk); pwr_off_req = 1'b0; pwr_on_req = 1'b0;
    end
    wait_idle;
    chk(err_code == 3'(code), "R8 err_code", err_code, code);
    chk(!bus_wr && !bus_rd, "R10 idle strobes", {bus_wr, bus_rd}, 0);
    if (code == 0) begin
      chk(powered && clk_en_sm && clk_en_ref && err_seen == 0, "R6 powered",
          {powered, clk_en_sm, clk_en_ref}, 7);
      base = 5 + la + 1;
      chk(lg_n == base + ra + 1, "R3 access count", lg_n, base + ra + 1);
      chk_acc(0, 1, T_DIV, exp_div(f), 1, "R2 divider write");
      chk_acc(1, 1, T_PLL, pll, 1, "R3 pll write");
      chk_acc(2, 1, T_BAND, {22'b0, band, band}, 1, "R4 band write");
      chk_acc(3, 0, T_SSM, 0, 0, "R3 startup read");
      chk_acc(4, 1, T_SSM, (ssm0 & 32'h1FE) | 32'h201, 1, "R5 startup write");
      for (int i = 5; i < base; i++) chk_acc(i, 0, T_PLL, 0, 0, "R6 lock poll");
      for (int i = base; i < lg_n; i++) chk_acc(i, 0, T_STAT, 0, 0, "R6 ready poll");
    end else begin
      chk(!clk_en_sm && !clk_en_ref && err_seen == 1, "R8 enables dropped",
          {clk_en_sm, clk_en_ref, 6'(err_seen)}, 1);
      chk(!powered, "R8 powered low", powered, 0);
      if (code == 2 || code == 1) chk(lg_n == 0, "R2 no access", lg_n, 0);
      if (code == 3) begin
        chk(lg_n == 2, "R4 stop before band", lg_n, 2);
        chk_acc(1, 1, T_PLL, pll, 1, "R4 pll write before fail");
      end
      if (code == 4) begin
        chk(lg_n >= 7, "R7 lock polled repeatedly", lg_n, 7);
        chk_acc(lg_n - 1, 0, T_PLL, 0, 0, "R7 last lock poll");
      end
      if (code == 5) begin
        chk(lg_n >= 8, "R7 ready polled repeatedly", lg_n, 8);
        chk_acc(lg_n - 1, 0, T_STAT, 0, 0, "R7 last ready poll");
      end
    end
  endtask

  task automatic run_off;
    logic [31:0] ssm0;
    logic [2:0] code0;
    ssm0 = ssm_reg; code0 = err_code; lg_n = 0;
    pulse(1'b0, 1'b1);
    chk(!clk_en_sm && !clk_en_ref, "R9 enables drop", {clk_en_sm, clk_en_ref}, 0);
    wait_idle;
    chk(lg_n == 2, "R9 access count", lg_n, 2);
    chk_acc(0, 0, T_SSM, 0, 0, "R9 read");
    chk_acc(1, 1, T_SSM, ssm0 & 32'hFFFF_FFFE, 1, "R9 write clears bit 0");
    chk(!powered, "R9 powered cleared", powered, 0);
    chk(err_code == code0, "R8 code sticky", err_code, code0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    us_tick = 1'b1;
    ssm_reg = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!powered && !clk_en_sm && !busy && err_code == 0 && !bus_wr && !bus_rd,
        "R8 reset state", {powered, clk_en_sm, busy, err_code}, 0);

    // R1: not configured
    run_up(50_000_000, 5'd3, 1, 32'h1234_5678, 0, 0, 0, 0, 1);
    cfg_valid = 1'b1;
    // directed ceiling frequency
    run_up(100_000_000, 5'd5, 1, 32'hA5A5_0F0F, 0, 0, 0, 0, 0);
    // R1: already powered
    lg_n = 0; err_seen = 0;
    pulse(1'b1, 1'b0);
    @(negedge clk);
    chk(powered && clk_en_sm && err_code == 1 && err_seen == 1 && lg_n == 0,
        "R1 reject while powered", {powered, clk_en_sm, err_code}, 'h19);
    run_off;

    // R2 boundaries
    run_up(0, 5'd1, 1, 32'h0, 0, 0, 0, 0, 2);
    run_up(100_000_001, 5'd1, 1, 32'h0, 0, 0, 0, 0, 2);
    run_up(1_499_999, 5'd2, 1, 32'h11, 1, 0, 0, 0, 0);
    run_off;
    run_up(1_500_000, 5'd31, 1, 32'h22, 0, 1, 0, 0, 0);
    run_off;

    // R4, R7 failures
    run_up(24_000_000, 5'd9, 0, 32'hCAFE_0001, 0, 0, 0, 0, 3);
    run_off;
    run_up(24_000_000, 5'd9, 1, 32'hCAFE_0002, 1000, 0, 0, 0, 4);
    run_up(24_000_000, 5'd9, 1, 32'hCAFE_0003, 0, 1000, 0, 0, 5);

    // random runs, with R11 stray and simultaneous requests
    for (int i = 0; i < 8; i++) begin
      ssm_reg = $urandom;
      run_up(1 + int'($urandom % 100_000_000), 5'($urandom), 1, $urandom,
             int'($urandom % 3), int'($urandom % 3), i == 4, i == 2, 0);
      run_off;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150_000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule